// File: doc/BRIEF.md
# Endian-Configurable Load/Store Aligner

This block sits between the load/store unit of a 32-bit datapath and a data memory that is addressed in bytes and returns whole 32-bit words. For a store it copies a byte, halfword or word of register data onto the right byte lanes and raises one write enable for each lane that is written. For a load it picks the addressed lanes out of the returned word and widens them to 32 bits, with sign extension or zero extension.

The byte numbering is chosen at run time by a mode pin. In big-endian mode the lowest address of a word selects bits 31..24. In little-endian mode it selects bits 7..0. The mode is sampled when each request is accepted. Any access whose address is not a multiple of its size is rejected: a flag pulses for one cycle and nothing reaches the memory.

Requests enter on a valid/ready stream. A request is taken on a cycle where `req_valid` and `req_ready` are both high, and the request fields must stay steady while `req_valid` is high and `req_ready` is low. Memory requests leave on a second valid/ready stream. The memory applies back-pressure by holding `mem_ready` low, and the aligner then holds the request steady. `req_ready` drops while a memory request is stalled and while a load is waiting for its data. Load data comes back on `mem_rvalid` and has no back-pressure. The widened result is presented as a single-cycle `ld_valid` pulse, and the consumer must take it in that cycle.

Top module: `endian_ls_aligner`

## Requirements
- R1: After reset `mem_valid`, `ld_valid` and `misalign` are low and `req_ready` is high.
- R2: A byte store (size code 00) drives the data byte on all four lanes. Its single write enable is bit `addr[1:0]` in little-endian mode and bit `3-addr[1:0]` in big-endian mode. Every memory request carries `mem_addr` with its two low bits cleared.
- R3: A halfword store (size code 01) drives the halfword on both halves. In little-endian mode the enables are 0011 for offset 0 and 1100 for offset 2. Big-endian mode swaps the two patterns.
- R4: A word store (size code 10) drives the data unchanged with enables 1111.
- R5: A misaligned request raises `misalign` for one cycle, in the cycle after it is accepted, and issues no memory request and no load result. A misaligned request is an odd halfword address, a word address that is not a multiple of 4, or the reserved size code 11.
- R6: A byte load returns the byte in lane `addr[1:0]` (little-endian) or lane `3-addr[1:0]` (big-endian). It is sign-extended when `req_signed` is 1 and zero-extended otherwise.
- R7: A halfword load returns bits 15..0 for little-endian offset 0 or big-endian offset 2. Any other aligned halfword offset returns bits 31..16. The result is extended as in R6.
- R8: A word load returns the memory word unchanged. Every load request carries write enables 1111 and `mem_write` low.
- R9: The endian mode is sampled at acceptance. A change of `big_endian` after a request is accepted does not alter that request's enables or its load result.
- R10: While `mem_valid` is high and `mem_ready` is low, the memory request holds steady and `req_ready` is low. `req_ready` also stays low from the acceptance of a load until its data returns.
- R11: A memory request appears in the cycle after acceptance. `ld_valid` pulses for exactly one cycle, in the cycle after `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| big_endian | input | 1 | 1 selects big-endian lane numbering, 0 selects little-endian |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 for a store, 0 for a load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_signed | input | 1 | Load extension: 1 sign, 0 zero |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory takes the request |
| mem_write | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Word address, low two bits zero |
| mem_be | output | 4 | Per-byte write enables |
| mem_wdata | output | 32 | Lane-placed store data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read word |
| ld_valid | output | 1 | Load result valid (one cycle) |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Rejected-access pulse |

## Verification
The bench targets the lane mirror between the two modes, using the same offset in each so that a design ignoring the mode shows a wrong enable bit or a wrong extracted byte. It loads bytes and halfwords with the top bit set, both signed and unsigned, to catch swapped or missing extension. It sends every class of misaligned request, including the reserved size, to catch a design that writes anyway or leaves the flag high. It flips the mode while a load is pending and while a store is stalled by `mem_ready`, to catch a design that reads the live pin instead of the sampled mode or that changes a request the memory has not yet taken.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int LANE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = LANE_W * WORD_BYTES;
  localparam int OFS_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  // context kept for an outstanding load
  typedef struct packed {
    acc_size_e        size;
    logic             sign_ext;
    logic             big_end;
    logic [OFS_W-1:0] ofs;
  } ld_ctx_t;
endpackage

// File: rtl/lsa_misalign_chk.sv
module lsa_misalign_chk
  import lsa_pkg::*;
(
  input  acc_size_e        size,
  input  logic [OFS_W-1:0] ofs,
  output logic             bad
);
  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = ofs[0];
      SZ_WORD: bad = |ofs;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsa_lane_map.sv
module lsa_lane_map
  import lsa_pkg::*;
(
  input  acc_size_e         size,
  input  logic [OFS_W-1:0]  ofs,
  input  logic              big_end,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_BYTES-1:0] be,
  output logic [WORD_W-1:0] lanes
);
  logic [OFS_W-1:0] byte_lane;
  logic             half_lane;

  // big-endian numbering mirrors the lane index
  assign byte_lane = ofs ^ {OFS_W{big_end}};
  assign half_lane = ofs[1] ^ big_end;

  for (genvar i = 0; i < WORD_BYTES; i++) begin : g_lane
    localparam logic [OFS_W-1:0] LI = i;
    always_comb begin
      unique case (size)
        SZ_BYTE: begin
          be[i]                  = (LI == byte_lane);
          lanes[i*LANE_W +: LANE_W] = wdata[LANE_W-1:0];
        end
        SZ_HALF: begin
          be[i]                  = (LI[1] == half_lane);
          lanes[i*LANE_W +: LANE_W] = wdata[LI[0]*LANE_W +: LANE_W];
        end
        SZ_WORD: begin
          be[i]                  = 1'b1;
          lanes[i*LANE_W +: LANE_W] = wdata[i*LANE_W +: LANE_W];
        end
        default: begin
          be[i]                  = 1'b0;
          lanes[i*LANE_W +: LANE_W] = '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_extract.sv
module lsa_load_extract
  import lsa_pkg::*;
(
  input  ld_ctx_t           ctx,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] result
);
  logic [OFS_W-1:0]    byte_lane;
  logic                half_lane;
  logic [LANE_W-1:0]   byte_v;
  logic [2*LANE_W-1:0] half_v;

  assign byte_lane = ctx.ofs ^ {OFS_W{ctx.big_end}};
  assign half_lane = ctx.ofs[1] ^ ctx.big_end;
  assign byte_v    = rdata[{byte_lane, 3'b000} +: LANE_W];
  assign half_v    = rdata[{half_lane, 4'b0000} +: 2*LANE_W];

  always_comb begin
    unique case (ctx.size)
      SZ_BYTE: result = {{(WORD_W-LANE_W){ctx.sign_ext & byte_v[LANE_W-1]}}, byte_v};
      SZ_HALF: result = {{(WORD_W-2*LANE_W){ctx.sign_ext & half_v[2*LANE_W-1]}}, half_v};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/endian_ls_aligner.sv
module endian_ls_aligner
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              big_endian,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic              req_signed,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  output logic [31:0]       ld_data,
  output logic              misalign
);
  acc_size_e             size_in;
  logic                  bad;
  logic                  accept;
  logic [WORD_BYTES-1:0] st_be;
  logic [WORD_W-1:0]     st_lanes;
  logic [WORD_W-1:0]     ld_ext;

  logic                  mem_valid_q, mem_write_q, pend_q, ld_valid_q, misalign_q;
  logic [ADDR_W-1:0]     mem_addr_q;
  logic [WORD_BYTES-1:0] mem_be_q;
  logic [WORD_W-1:0]     mem_wdata_q, ld_data_q;
  ld_ctx_t               ctx_q;

  assign size_in   = acc_size_e'(req_size);
  assign req_ready = (!mem_valid_q || mem_ready) && !pend_q;
  assign accept    = req_valid && req_ready;

  lsa_misalign_chk u_chk (
    .size (size_in),
    .ofs  (req_addr[OFS_W-1:0]),
    .bad  (bad)
  );

  lsa_lane_map u_map (
    .size    (size_in),
    .ofs     (req_addr[OFS_W-1:0]),
    .big_end (big_endian),
    .wdata   (req_wdata),
    .be      (st_be),
    .lanes   (st_lanes)
  );

  lsa_load_extract u_ext (
    .ctx    (ctx_q),
    .rdata  (mem_rdata),
    .result (ld_ext)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_valid_q <= 1'b0;
      mem_write_q <= 1'b0;
      mem_addr_q  <= '0;
      mem_be_q    <= '0;
      mem_wdata_q <= '0;
      pend_q      <= 1'b0;
      ctx_q       <= '0;
      ld_valid_q  <= 1'b0;
      ld_data_q   <= '0;
      misalign_q  <= 1'b0;
    end else begin
      misalign_q <= accept && bad;
      if (mem_valid_q && mem_ready) mem_valid_q <= 1'b0;
      if (accept && !bad) begin
        mem_valid_q <= 1'b1;
        mem_write_q <= req_write;
        mem_addr_q  <= {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        mem_be_q    <= req_write ? st_be : {WORD_BYTES{1'b1}};
        mem_wdata_q <= req_write ? st_lanes : '0;
        if (!req_write) begin
          pend_q <= 1'b1;
          ctx_q  <= '{size: size_in, sign_ext: req_signed,
                      big_end: big_endian, ofs: req_addr[OFS_W-1:0]};
        end
      end
      ld_valid_q <= 1'b0;
      if (pend_q && mem_rvalid) begin
        pend_q     <= 1'b0;
        ld_valid_q <= 1'b1;
        ld_data_q  <= ld_ext;
      end
    end
  end

  assign mem_valid = mem_valid_q;
  assign mem_write = mem_write_q;
  assign mem_addr  = mem_addr_q;
  assign mem_be    = mem_be_q;
  assign mem_wdata = mem_wdata_q;
  assign ld_valid  = ld_valid_q;
  assign ld_data   = ld_data_q;
  assign misalign  = misalign_q;
endmodule

// File: rtl/lsa_checker.sv
module lsa_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              ld_valid,
  input logic              misalign
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_be)
                               && $stable(mem_wdata) && $stable(mem_write));

  // R10
  ready_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |-> !req_ready);

  // R5
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> !mem_valid && !ld_valid);

  // R2
  word_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> mem_addr[1:0] == 2'b00);

  // R3
  store_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_write |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2
                                || $countones(mem_be) == 4));

  // R8
  load_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |-> mem_be == 4'hF);

  // R11
  ld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> !ld_valid);
endmodule

bind endian_ls_aligner lsa_checker #(.ADDR_W(ADDR_W)) u_lsa_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_write (mem_write),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .ld_valid  (ld_valid),
  .misalign  (misalign)
);

// File: tb/endian_ls_aligner_tb.sv
module endian_ls_aligner_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic        req_signed = 1'b0;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        mem_valid;
  logic        mem_ready = 1'b1;
  logic        mem_write;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid;
  logic [31:0] ld_data;
  logic        misalign;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  endian_ls_aligner u_dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // offer a request and return at the negedge after it was accepted
  task automatic issue(input logic be_mode, input logic wr, input logic [1:0] sz,
                       input logic sgn, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    big_endian = be_mode; req_write = wr; req_size = sz; req_signed = sgn;
    req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_store(input string tag, input logic be_mode, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] d,
                         input logic [3:0] exp_be, input logic [31:0] exp_wd);
    issue(be_mode, 1'b1, sz, 1'b0, a, d);
    chk({tag, " valid"}, {31'd0, mem_valid & mem_write}, 32'd1);
    chk({tag, " addr"}, mem_addr, {a[31:2], 2'b00});
    chk({tag, " be"}, {28'd0, mem_be}, {28'd0, exp_be});
    chk({tag, " wdata"}, mem_wdata, exp_wd);
    @(negedge clk);
    chk({tag, " drained"}, {31'd0, mem_valid}, 32'd0);
  endtask

  task automatic t_load(input string tag, input logic be_mode, input logic flip,
                        input logic [1:0] sz, input logic sgn, input logic [31:0] a,
                        input logic [31:0] rd, input logic [31:0] exp);
    issue(be_mode, 1'b0, sz, sgn, a, 32'd0);
    if (flip) big_endian = ~be_mode;
    chk({tag, " rd req"}, {30'd0, mem_valid, mem_write}, 32'd2);
    chk({tag, " rd be"}, {28'd0, mem_be}, 32'hF);
    chk({tag, " busy"}, {31'd0, req_ready}, 32'd0);
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = rd;
    @(negedge clk);
    mem_rvalid = 1'b0;
    chk({tag, " ld_valid"}, {31'd0, ld_valid}, 32'd1);
    chk({tag, " data"}, ld_data, exp);
    @(negedge clk);
    chk({tag, " pulse"}, {31'd0, ld_valid}, 32'd0);
  endtask

  task automatic t_misalign(input string tag, input logic wr, input logic [1:0] sz,
                            input logic [31:0] a);
    issue(1'b0, wr, sz, 1'b0, a, 32'h55AA55AA);
    chk({tag, " flag"}, {30'd0, misalign, mem_valid}, 32'd2);
    @(negedge clk);
    chk({tag, " flag drop"}, {29'd0, misalign, mem_valid, ld_valid}, 32'd0);
    chk({tag, " ready"}, {31'd0, req_ready}, 32'd1);
  endtask

  task automatic t_stall();
    mem_ready = 1'b0;
    issue(1'b1, 1'b1, 2'b00, 1'b0, 32'h0000_0040, 32'h0000_007E);
    big_endian = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R10 stall valid", {31'd0, mem_valid}, 32'd1);
      chk("R10 stall ready", {31'd0, req_ready}, 32'd0);
      chk("R9 stall be", {28'd0, mem_be}, 32'h8);
      @(negedge clk);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    chk("R10 release", {31'd0, mem_valid}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {29'd0, mem_valid, ld_valid, misalign}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);

    t_store("R2 byte LE", 1'b0, 2'b00, 32'h0000_0101, 32'h0000_00A5, 4'b0010, 32'hA5A5_A5A5);
    t_store("R2 byte BE", 1'b1, 2'b00, 32'h0000_0101, 32'h0000_00A5, 4'b0100, 32'hA5A5_A5A5);
    t_store("R3 half LE", 1'b0, 2'b01, 32'h0000_0202, 32'h0000_1234, 4'b1100, 32'h1234_1234);
    t_store("R3 half BE", 1'b1, 2'b01, 32'h0000_0202, 32'h0000_1234, 4'b0011, 32'h1234_1234);
    t_store("R3 half BE0", 1'b1, 2'b01, 32'h0000_0200, 32'h0000_BEEF, 4'b1100, 32'hBEEF_BEEF);
    t_store("R4 word", 1'b1, 2'b10, 32'h0000_0300, 32'hDEAD_BEEF, 4'b1111, 32'hDEAD_BEEF);

    t_load("R6 byte LE s", 1'b0, 1'b0, 2'b00, 1'b1, 32'h13, 32'h8844_2211, 32'hFFFF_FF88);
    t_load("R6 byte LE u", 1'b0, 1'b0, 2'b00, 1'b0, 32'h13, 32'h8844_2211, 32'h0000_0088);
    t_load("R6 byte BE s", 1'b1, 1'b0, 2'b00, 1'b1, 32'h10, 32'h8844_2211, 32'hFFFF_FF88);
    t_load("R6 byte BE", 1'b1, 1'b0, 2'b00, 1'b1, 32'h13, 32'h8844_2211, 32'h0000_0011);
    t_load("R7 half LE s", 1'b0, 1'b0, 2'b01, 1'b1, 32'h22, 32'h80F0_7F01, 32'hFFFF_80F0);
    t_load("R7 half BE s", 1'b1, 1'b0, 2'b01, 1'b1, 32'h22, 32'h80F0_7F01, 32'h0000_7F01);
    t_load("R7 half BE u", 1'b1, 1'b0, 2'b01, 1'b0, 32'h20, 32'h80F0_7F01, 32'h0000_80F0);
    t_load("R8 word LE", 1'b0, 1'b0, 2'b10, 1'b1, 32'h30, 32'h80F0_7F01, 32'h80F0_7F01);
    t_load("R8 word BE", 1'b1, 1'b0, 2'b10, 1'b1, 32'h30, 32'h80F0_7F01, 32'h80F0_7F01);
    t_load("R9 mode flip", 1'b1, 1'b1, 2'b00, 1'b0, 32'h41, 32'h1122_3344, 32'h0000_0022);

    t_misalign("R5 half odd", 1'b1, 2'b01, 32'h0000_0101);
    t_misalign("R5 word off2", 1'b1, 2'b10, 32'h0000_0102);
    t_misalign("R5 word off1 load", 1'b0, 2'b10, 32'h0000_0101);
    t_misalign("R5 reserved", 1'b1, 2'b11, 32'h0000_0100);

    t_stall();

    // R11 request appears one cycle after acceptance (checked inside t_store timing)
    t_store("R11 timing", 1'b0, 2'b00, 32'h0000_0503, 32'h0000_0011, 4'b1000, 32'h1111_1111);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule